// File: doc/BRIEF.md
# Phase-Coherent Tunable Oscillator Bank

This block is the local-oscillator stage of a multi-channel digital down-converter. It holds one frequency word per channel for a bank of channels (eight by default) sharing one sample stream. Each word is written through a small select-and-strobe port. For every sample tick the bank produces a phase word per channel, together with signed sine and cosine values read from a quarter-wave table. A mixer downstream uses these to shift its sub-band to baseband.

The phase is not built by adding the frequency word into an accumulator on each sample. It is the product of the channel's frequency word and an absolute sample index. That index counts ticks since the last one-pulse-per-second epoch. The phase at any sample therefore depends only on the current word and elapsed time. A channel that is retuned elsewhere and later returned to an earlier word lands on exactly the phase it would have had if it had never moved.

The frequency word is in units of 2^-PW turns per sample. With the default 32-bit word and a 1024 MHz sample rate, one step is about 0.24 Hz, so any centre frequency in the 512 MHz channel can be set to better than 1 Hz. The sample tick acts as an input valid with no ready: every tick is taken. The output stream has a valid but no back-pressure, so the consumer must take each beat in the cycle it appears. Filtering and decimation are not part of this block.

Top module: `nco_coherent_bank`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0, and every out_phase, out_sin and out_cos field is 0. All frequency words reset to 0, so samples taken before any write have phase 0.
- R2: Each cycle with smp_tick high produces exactly one output beat, with out_valid high exactly three cycles later. No beat appears otherwise.
- R3: For channel c, out_phase bits [c*PW +: PW] equal (word_c × n) mod 2^PW. Here word_c is channel c's frequency word and n is the sample's index, counted in ticks since the last epoch.
- R4: A tick in the same cycle as pps_strobe gets index 0. A pps_strobe without a tick makes the next tick get index 0. Following ticks count 1, 2, 3 and so on.
- R5: A write (cfg_wr high, channel cfg_sel, value cfg_freq) applies to ticks in later cycles. A tick in the same cycle as the write still uses the previous word.
- R6: After a channel is tuned to another word and then back, its phase at every later sample equals the phase it would have had without the detour.
- R7: A write changes only the selected channel. Every other channel's phase sequence continues unchanged.
- R8: With j the top LB bits of a channel's phase, out_sin is round(A·sin(2π(j+0.5)/2^LB)) and out_cos is round(A·cos(2π(j+0.5)/2^LB)), where A = 2^(AW-1)-1. Both are signed AW-bit two's complement. As a result, sin is negative exactly when the phase MSB is 1, and cos is negative exactly when the two top phase bits differ.
- R9: In cycles where out_valid is 0, out_phase, out_sin and out_cos keep the values of the last beat (or the reset values).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_tick | input | 1 | One sample instant per high cycle |
| pps_strobe | input | 1 | Epoch strobe; restarts the sample index |
| cfg_wr | input | 1 | Frequency word write strobe |
| cfg_sel | input | SW = clog2(NCH) | Channel written |
| cfg_freq | input | PW | New frequency word, 2^-PW turns per sample |
| out_valid | output | 1 | Output beat valid, no back-pressure |
| out_phase | output | NCH*PW | Per-channel phase words, channel c at [c*PW +: PW] |
| out_sin | output | NCH*AW | Per-channel signed sine, channel c at [c*AW +: AW] |
| out_cos | output | NCH*AW | Per-channel signed cosine, channel c at [c*AW +: AW] |

## Verification
The hardest situations to reach are the ones where two control events fall in the same cycle as a tick. One is a write landing on a tick, where the old word must still apply. The other is an epoch strobe arriving on a tick, or between ticks, where either the current or the next sample must restart at index zero. The stimulus places these coincidences on purpose, inside gapped tick patterns as well as back-to-back ones. It also drives one channel away from a word and back while its neighbours run, so the return-to-phase property is checked against pure elapsed time. A long pseudo-random run with mixed words and tick gaps then compares every channel on every clock against a model that only multiplies word by index.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam real TWO_PI_HALF = 3.14159265358979323846 / 2.0;

  // Amplitude of quarter-wave entry k out of qn entries, sampled at bin centres.
  function automatic int quarter_amp(input int k, input int qn, input int aw);
    real peak;
    real ang;
    peak = real'((1 << (aw - 1)) - 1);
    ang  = TWO_PI_HALF * (real'(k) + 0.5) / real'(qn);
    return int'(peak * $sin(ang));
  endfunction

endpackage

// File: rtl/nco_epoch_counter.sv
module nco_epoch_counter #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pps,
  output logic [PW-1:0] idx
);
  logic [PW-1:0] cnt_q;
  logic          restart_q;

  // index used by the sample in this cycle
  assign idx = (pps || restart_q) ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      restart_q <= 1'b0;
    end else if (tick) begin
      cnt_q     <= idx + PW'(1);
      restart_q <= 1'b0;
    end else if (pps) begin
      restart_q <= 1'b1;
    end
  end
endmodule

// File: rtl/nco_phase_mult.sv
module nco_phase_mult #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_a,
  input  logic          en_b,
  input  logic [PW-1:0] word,
  input  logic [PW-1:0] idx,
  output logic [PW-1:0] phase
);
  localparam int HW = PW / 2;
  localparam int LW = PW - HW;

  logic [PW-1:0] lo_prod_q;
  logic [HW-1:0] cross_q;
  logic [PW-1:0] lo_prod_d;
  logic [HW-1:0] cross_d;

  // only the low PW bits of the product matter: modulo one turn
  always_comb begin
    lo_prod_d = PW'(word[LW-1:0]) * PW'(idx[LW-1:0]);
    cross_d   = HW'(word[PW-1:LW] * HW'(idx[LW-1:0]))
              + HW'(HW'(word[LW-1:0]) * idx[PW-1:LW]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_prod_q <= '0;
      cross_q   <= '0;
    end else if (en_a) begin
      lo_prod_q <= lo_prod_d;
      cross_q   <= cross_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (en_b) begin
      phase <= lo_prod_q + {cross_q, {LW{1'b0}}};
    end
  end
endmodule

// File: rtl/nco_wave_lut.sv
module nco_wave_lut #(
  parameter int PW = 32,
  parameter int LB = 8,
  parameter int AW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [PW-1:0]        phase_in,
  output logic [PW-1:0]        phase_out,
  output logic signed [AW-1:0] sin_out,
  output logic signed [AW-1:0] cos_out
);
  localparam int QB = LB - 2;
  localparam int QN = 1 << QB;
  localparam int MW = AW - 1;

  logic [MW-1:0]        qtab [QN];
  logic signed [AW-1:0] wave_d [2];

  for (genvar k = 0; k < QN; k++) begin : g_tab
    assign qtab[k] = MW'(nco_pkg::quarter_amp(k, QN, AW));
  end

  // w = 0 gives sine; w = 1 advances a quarter turn for cosine
  for (genvar w = 0; w < 2; w++) begin : g_wave
    logic [LB-1:0] pos;
    logic [QB-1:0] addr;
    logic [MW-1:0] mag;
    always_comb begin
      pos       = phase_in[PW-1 -: LB] + LB'(w * QN);
      addr      = pos[LB-2] ? ~pos[QB-1:0] : pos[QB-1:0];
      mag       = qtab[addr];
      wave_d[w] = pos[LB-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_out <= '0;
      sin_out   <= '0;
      cos_out   <= '0;
    end else if (en) begin
      phase_out <= phase_in;
      sin_out   <= wave_d[0];
      cos_out   <= wave_d[1];
    end
  end
endmodule

// File: rtl/nco_coherent_bank.sv
module nco_coherent_bank #(
  parameter int PW  = 32,
  parameter int NCH = 8,
  parameter int LB  = 8,
  parameter int AW  = 12,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_tick,
  input  logic              pps_strobe,
  input  logic              cfg_wr,
  input  logic [SW-1:0]     cfg_sel,
  input  logic [PW-1:0]     cfg_freq,
  output logic              out_valid,
  output logic [NCH*PW-1:0] out_phase,
  output logic [NCH*AW-1:0] out_sin,
  output logic [NCH*AW-1:0] out_cos
);
  localparam int LAT = 3;

  logic [PW-1:0]  word_q [NCH];
  logic [PW-1:0]  samp_idx;
  logic [LAT-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) word_q[c] <= '0;
    end else if (cfg_wr && (int'(cfg_sel) < NCH)) begin
      word_q[cfg_sel] <= cfg_freq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[LAT-2:0], smp_tick};
  end
  assign out_valid = vld_q[LAT-1];

  nco_epoch_counter #(.PW(PW)) u_epoch (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (smp_tick),
    .pps   (pps_strobe),
    .idx   (samp_idx)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [PW-1:0] ph;

    nco_phase_mult #(.PW(PW)) u_mult (
      .clk   (clk),
      .rst_n (rst_n),
      .en_a  (smp_tick),
      .en_b  (vld_q[0]),
      .word  (word_q[c]),
      .idx   (samp_idx),
      .phase (ph)
    );

    nco_wave_lut #(.PW(PW), .LB(LB), .AW(AW)) u_lut (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (vld_q[1]),
      .phase_in  (ph),
      .phase_out (out_phase[c*PW +: PW]),
      .sin_out   (out_sin[c*AW +: AW]),
      .cos_out   (out_cos[c*AW +: AW])
    );
  end
endmodule

// File: rtl/nco_coherent_checker.sv
module nco_coherent_checker #(
  parameter int PW  = 32,
  parameter int NCH = 8,
  parameter int AW  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_tick,
  input logic              pps_strobe,
  input logic              out_valid,
  input logic [NCH*PW-1:0] out_phase,
  input logic [NCH*AW-1:0] out_sin,
  input logic [NCH*AW-1:0] out_cos
);
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n)            seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  assert_beat_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3) |-> (out_valid == $past(smp_tick, 3)));

  assert_epoch_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((seen == 2'd3) && $past(smp_tick && pps_strobe, 3)) |-> (out_phase == '0));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((seen != 2'd0) && !out_valid) |->
      ($stable(out_phase) && $stable(out_sin) && $stable(out_cos)));

  for (genvar c = 0; c < NCH; c++) begin : g_sign
    assert_sin_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sin[c*AW+AW-1] == out_phase[c*PW+PW-1]));
    assert_cos_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_cos[c*AW+AW-1] == (out_phase[c*PW+PW-1] ^ out_phase[c*PW+PW-2])));
  end
endmodule

bind nco_coherent_bank nco_coherent_checker #(.PW(PW), .NCH(NCH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_tick   (smp_tick),
  .pps_strobe (pps_strobe),
  .out_valid  (out_valid),
  .out_phase  (out_phase),
  .out_sin    (out_sin),
  .out_cos    (out_cos)
);

// File: tb/nco_coherent_bank_test.sv
module nco_coherent_bank_test;
  localparam int PW  = 32;
  localparam int NCH = 8;
  localparam int LB  = 8;
  localparam int AW  = 12;
  localparam int SW  = 3;
  localparam real PI = 3.14159265358979323846;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_tick = 1'b0;
  logic              pps_strobe = 1'b0;
  logic              cfg_wr = 1'b0;
  logic [SW-1:0]     cfg_sel = '0;
  logic [PW-1:0]     cfg_freq = '0;
  logic              out_valid;
  logic [NCH*PW-1:0] out_phase;
  logic [NCH*AW-1:0] out_sin;
  logic [NCH*AW-1:0] out_cos;

  always #4 clk = ~clk;

  nco_coherent_bank #(.PW(PW), .NCH(NCH), .LB(LB), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .pps_strobe(pps_strobe),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_freq(cfg_freq),
    .out_valid(out_valid), .out_phase(out_phase), .out_sin(out_sin), .out_cos(out_cos)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference state: words, ticks since epoch, pending restart
  bit [PW-1:0]     m_word [NCH];
  bit [PW-1:0]     m_count = '0;
  bit              m_restart = 1'b0;
  bit              q_vld [$];
  bit [NCH*PW-1:0] q_ph [$];
  string           q_req [$];
  bit [NCH*PW-1:0] last_ph = '0;
  bit [NCH*AW-1:0] last_sin = '0;
  bit [NCH*AW-1:0] last_cos = '0;
  bit [31:0]       lcg = 32'h1234_5678;

  function automatic bit [AW-1:0] ref_wave(input bit [PW-1:0] ph, input bit want_cos);
    real ang;
    real amp;
    real v;
    ang = 2.0 * PI * (real'(ph[PW-1 -: LB]) + 0.5) / real'(1 << LB);
    amp = real'((1 << (AW - 1)) - 1);
    v   = want_cos ? $cos(ang) : $sin(ang);
    return AW'(int'(amp * v));
  endfunction

  task automatic check_out();
    bit              v;
    bit [NCH*PW-1:0] ph;
    string           req;
    v   = q_vld.pop_front();
    ph  = q_ph.pop_front();
    req = q_req.pop_front();
    if (v) begin
      last_ph = ph;
      for (int c = 0; c < NCH; c++) begin
        last_sin[c*AW +: AW] = ref_wave(ph[c*PW +: PW], 1'b0);
        last_cos[c*AW +: AW] = ref_wave(ph[c*PW +: PW], 1'b1);
      end
    end
    checks++;
    if (out_valid !== v || out_phase !== last_ph || out_sin !== last_sin || out_cos !== last_cos) begin
      errors++;
      $display("FAIL %s: got valid=%0b phase=%h sin=%h cos=%h, expected valid=%0b phase=%h sin=%h cos=%h",
               req, out_valid, out_phase, out_sin, out_cos, v, last_ph, last_sin, last_cos);
    end
  endtask

  task automatic step(input bit tk, input bit pp, input bit wr, input int sel,
                      input bit [PW-1:0] fr, input string req);
    bit [NCH*PW-1:0] ph;
    bit [PW-1:0]     idx;
    @(negedge clk);
    check_out();
    smp_tick   = tk;
    pps_strobe = pp;
    cfg_wr     = wr;
    cfg_sel    = SW'(sel);
    cfg_freq   = fr;
    ph = '0;
    if (tk) begin
      idx = (pp || m_restart) ? '0 : m_count;
      for (int c = 0; c < NCH; c++) ph[c*PW +: PW] = m_word[c] * idx;
      m_count   = idx + 1;
      m_restart = 1'b0;
    end else if (pp) begin
      m_restart = 1'b1;
    end
    if (wr) m_word[sel] = fr;
    q_vld.push_back(tk);
    q_ph.push_back(ph);
    q_req.push_back(req);
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 0, '0, req);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) m_word[c] = '0;
    repeat (4) @(negedge clk);
    // R1: reset values visible while held
    checks++;
    if (out_valid !== 1'b0 || out_phase !== '0 || out_sin !== '0 || out_cos !== '0) begin
      errors++;
      $display("FAIL R1: got valid=%0b phase=%h, expected valid=0 phase=0", out_valid, out_phase);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      q_vld.push_back(1'b0);
      q_ph.push_back('0);
      q_req.push_back("R1");
    end
    // R1: words are zero after reset, so phases stay zero
    ticks(5, "R1");
    step(1'b0, 1'b0, 1'b0, 0, '0, "R1");
    // R7: load distinct words one channel at a time
    for (int c = 0; c < NCH; c++)
      step(1'b0, 1'b0, 1'b1, c, 32'h0123_4567 * (c + 3) + 32'd1, "R7");
    // R3: back-to-back samples
    ticks(24, "R3");
    // R2: gapped samples
    for (int i = 0; i < 18; i++) step((i % 3) == 0, 1'b0, 1'b0, 0, '0, "R2");
    // R4: epoch strobe alone, then on a tick
    step(1'b0, 1'b1, 1'b0, 0, '0, "R4");
    step(1'b0, 1'b0, 1'b0, 0, '0, "R4");
    ticks(4, "R4");
    step(1'b1, 1'b1, 1'b0, 0, '0, "R4");
    ticks(3, "R4");
    // R5: write in the same cycle as a tick keeps old word for that tick
    step(1'b1, 1'b0, 1'b1, 1, 32'h7FFF_0001, "R5");
    ticks(3, "R5");
    step(1'b0, 1'b0, 1'b1, 4, 32'h0000_0001, "R5");
    step(1'b1, 1'b0, 1'b0, 0, '0, "R5");
    // R6: detour on channel 2 then return
    step(1'b1, 1'b0, 1'b1, 2, 32'h3333_3333, "R6");
    ticks(5, "R6");
    step(1'b1, 1'b0, 1'b1, 2, 32'h0123_4567 * 5 + 32'd1, "R6");
    ticks(8, "R6");
    // R7: one channel changes while others continue
    step(1'b0, 1'b0, 1'b1, 5, 32'hDEAD_BEEF, "R7");
    ticks(6, "R7");
    // R8: slow sweep through all quadrants on channel 0
    step(1'b1, 1'b1, 1'b1, 0, 32'h0100_0137, "R8");
    ticks(300, "R8");
    // R9: sparse beats with long idle gaps
    for (int i = 0; i < 30; i++) step((i % 7) == 0, 1'b0, 1'b0, 0, '0, "R9");
    // R3: pseudo-random words, ticks and epochs
    for (int i = 0; i < 3000; i++) begin
      bit tk, pp, wr;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      tk = lcg[9:8] != 2'b00;
      pp = lcg[20:14] == 7'd5;
      wr = lcg[27:25] == 3'd1;
      step(tk, pp, wr, int'(lcg[31:29]), lcg ^ {lcg[15:0], lcg[31:16]}, "R3");
    end
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, 0, '0, "R9");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule